// File: doc/BRIEF.md
# Current-Sense ADC Register Block

This block is the register-side front end of a current-sense ADC peripheral. A host talks to it over a byte-wide bus with separate read and write strobes. Through that bus it reads the identification bytes and sets up the conversion: operating mode, channel, decimation, settle delay and averaging. It then switches the peripheral on and asks for a conversion. On the other side, the block drives a converter with a start pulse and the chosen channel. When the converter answers with a done pulse and a 16-bit sample, the block stores the sample, updates its status and raises an interrupt.

One control byte, the reset-behaviour register, is guarded by a key. The host must write the key byte to the key register immediately before touching it. The next bus access of any kind uses the key up. Without a fresh key, the guarded register reads as zero and ignores writes. A factory byte for sense-resistor deviation is read-only and is set by a parameter.

Top module: `csadc_regif`

## Requirements
- R1: The identification bytes are read-only: address 0x01 reads 0x01, 0x04 reads 0x08 and 0x05 reads 0x03, and writes to them leave these values unchanged.
- R2: After reset, status (0x08) reads 0x00, the mode register (0x40) and result low byte (0x60) read 0x00, and both irq and conv_start are low.
- R3: The mode (0x40), channel (0x48), decimation (0x50), settle (0x51) and averaging (0x5A) registers read back the full byte written. The enable register (0x46) and the fast-average register (0x5B) keep only bit 7; their other bits read 0.
- R4: While enable bit 7 of 0x46 is set and no conversion is pending, writing 0x52 with bit 7 set gives a conv_start pulse exactly one cycle long in the cycle after the write. conv_chan then carries the low CHAN_W bits of 0x48, and status bits [1:0] read 2'b10 (bit 1 request pending, bit 0 end of conversion).
- R5: A write to 0x52 while the peripheral is disabled, or with bit 7 clear, is ignored: there is no start pulse and the status is unchanged.
- R6: A conv_done pulse during a pending conversion stores conv_sample and sets status [1:0] to 2'b01. The result is read low byte at 0x60 and high byte at 0x61.
- R7: irq goes high when a conversion completes and stays high until a new conversion request is accepted, which clears it.
- R8: A conversion request written while one is already pending is ignored and produces no second start pulse.
- R9: A conv_done pulse with no conversion pending leaves the result and the status unchanged.
- R10: Writing 0xA5 to 0xD0 unlocks the reset-control register (0xDA) for exactly the next access, which may read or write the whole byte (bit 2 selects warm-reset following).
- R11: An access to 0xDA without a fresh unlock reads 0x00 and ignores writes. Any other access in between, or a write of a byte other than 0xA5 to 0xD0, cancels the unlock.
- R12: Address 0xF4 reads the DEV_BYTE parameter, and unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | DATA_W | Read data, valid the cycle after bus_rd when RDATA_REG=1 |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_chan | output | CHAN_W | Channel captured at conversion start |
| conv_done | input | 1 | Converter completion pulse |
| conv_sample | input | RES_W | Converter sample, valid with conv_done |
| irq | output | 1 | Level end-of-conversion interrupt |

## Verification
Conversion requests are tried in four states: disabled, enabled but with the request bit clear, enabled and idle, and enabled with a conversion already pending. Together these separate the acceptance gating from the handling of the request bit. Done pulses arrive both with and without a pending conversion, using two distinct samples with asymmetric bytes, so a stray capture or a swapped byte lane shows up in the result reads. The key sequence is tried in four forms to show that the unlock is one-shot and tied to the exact key value: absent, correct, cancelled by an access in between, and written with the wrong byte.

// File: rtl/csadc_pkg.sv
package csadc_pkg;
   localparam logic [7:0] A_REV     = 8'h01;
   localparam logic [7:0] A_PTYPE   = 8'h04;
   localparam logic [7:0] A_PSUB    = 8'h05;
   localparam logic [7:0] A_STATUS  = 8'h08;
   localparam logic [7:0] A_MODE    = 8'h40;
   localparam logic [7:0] A_ENABLE  = 8'h46;
   localparam logic [7:0] A_CHAN    = 8'h48;
   localparam logic [7:0] A_DECIM   = 8'h50;
   localparam logic [7:0] A_SETTLE  = 8'h51;
   localparam logic [7:0] A_REQ     = 8'h52;
   localparam logic [7:0] A_AVG     = 8'h5A;
   localparam logic [7:0] A_FASTAVG = 8'h5B;
   localparam logic [7:0] A_RESULT  = 8'h60;
   localparam logic [7:0] A_KEY     = 8'hD0;
   localparam logic [7:0] A_RSTCTL  = 8'hDA;
   localparam logic [7:0] A_DEVIATE = 8'hF4;

   localparam logic [7:0] KEY_BYTE  = 8'hA5;
   localparam logic [7:0] ID_REV    = 8'h01;
   localparam logic [7:0] ID_PTYPE  = 8'h08;
   localparam logic [7:0] ID_PSUB   = 8'h03;
endpackage

// File: rtl/csadc_unlock.sv
module csadc_unlock
   import csadc_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              wr_i,
   input  logic              rd_i,
   output logic              armed_o
);
   logic key_hit;
   logic any_acc;

   assign any_acc = wr_i | rd_i;
   assign key_hit = wr_i && (addr_i == A_KEY) && (wdata_i == KEY_BYTE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       armed_o <= 1'b0;
      else if (any_acc) armed_o <= key_hit;
   end

   assert_unlock_one_shot_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_o && rd_i) |=> !armed_o);
   assert_unlock_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_i && !rd_i) |=> $stable(armed_o));
endmodule

// File: rtl/csadc_conv_ctl.sv
module csadc_conv_ctl #(
   parameter int CHAN_W = 3,
   parameter int RES_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              en_i,
   input  logic [CHAN_W-1:0] chan_i,
   input  logic              done_i,
   input  logic [RES_W-1:0]  sample_i,
   output logic              start_o,
   output logic [CHAN_W-1:0] chan_o,
   output logic              pending_o,
   output logic              eoc_o,
   output logic [RES_W-1:0]  result_o
);
   logic accept;
   logic finish;

   assign accept = req_i & en_i & ~pending_o;
   assign finish = done_i & pending_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_o   <= 1'b0;
         chan_o    <= '0;
         pending_o <= 1'b0;
         eoc_o     <= 1'b0;
         result_o  <= '0;
      end else begin
         start_o <= accept;
         if (accept) begin
            chan_o    <= chan_i;
            pending_o <= 1'b1;
            eoc_o     <= 1'b0;
         end else if (finish) begin
            pending_o <= 1'b0;
            eoc_o     <= 1'b1;
            result_o  <= sample_i;
         end
      end
   end

   assert_start_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> !start_o);
   assert_start_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> (pending_o && !eoc_o));
   assert_start_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pending_o) |-> $past(en_i));
   assert_done_completes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pending_o && done_i && !req_i) |=> (eoc_o && !pending_o));
   assert_stray_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!pending_o && !accept) |=> $stable(result_o));
   assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pending_o |=> !start_o);
endmodule

// File: rtl/csadc_regif.sv
module csadc_regif
   import csadc_pkg::*;
#(
   parameter int         ADDR_W    = 8,
   parameter int         DATA_W    = 8,
   parameter int         CHAN_W    = 3,
   parameter int         RES_W     = 16,
   parameter bit         RDATA_REG = 1'b1,
   parameter logic [7:0] DEV_BYTE  = 8'h85
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              conv_start,
   output logic [CHAN_W-1:0] conv_chan,
   input  logic              conv_done,
   input  logic [RES_W-1:0]  conv_sample,
   output logic              irq
);
   localparam int RES_BYTES = RES_W / 8;

   if (ADDR_W != 8) begin : g_bad_addr
      $error("csadc_regif: ADDR_W must be 8");
   end
   if (DATA_W != 8) begin : g_bad_data
      $error("csadc_regif: DATA_W must be 8");
   end
   if ((RES_W % 8) != 0 || RES_BYTES < 1 || RES_BYTES > 4) begin : g_bad_res
      $error("csadc_regif: RES_W must be 8, 16, 24 or 32");
   end
   if (CHAN_W < 1 || CHAN_W > 8) begin : g_bad_chan
      $error("csadc_regif: CHAN_W must be 1..8");
   end

   logic [7:0] mode_q, chan_q, decim_q, settle_q, avg_q, rstctl_q;
   logic       en_q, fastavg_q;
   logic       armed;
   logic       pending, eoc;
   logic [RES_W-1:0] result;
   logic [7:0] rd_mux;
   logic       req_wr;

   csadc_unlock #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_unlock (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr_i  (bus_addr),
      .wdata_i (bus_wdata),
      .wr_i    (bus_wr),
      .rd_i    (bus_rd),
      .armed_o (armed)
   );

   assign req_wr = bus_wr && (bus_addr == A_REQ) && bus_wdata[7];

   csadc_conv_ctl #(.CHAN_W(CHAN_W), .RES_W(RES_W)) u_conv (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (req_wr),
      .en_i      (en_q),
      .chan_i    (chan_q[CHAN_W-1:0]),
      .done_i    (conv_done),
      .sample_i  (conv_sample),
      .start_o   (conv_start),
      .chan_o    (conv_chan),
      .pending_o (pending),
      .eoc_o     (eoc),
      .result_o  (result)
   );

   assign irq = eoc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= '0;
         chan_q    <= '0;
         decim_q   <= '0;
         settle_q  <= '0;
         avg_q     <= '0;
         rstctl_q  <= '0;
         en_q      <= 1'b0;
         fastavg_q <= 1'b0;
      end else if (bus_wr) begin
         unique case (bus_addr)
            A_MODE:    mode_q    <= bus_wdata;
            A_CHAN:    chan_q    <= bus_wdata;
            A_DECIM:   decim_q   <= bus_wdata;
            A_SETTLE:  settle_q  <= bus_wdata;
            A_AVG:     avg_q     <= bus_wdata;
            A_ENABLE:  en_q      <= bus_wdata[7];
            A_FASTAVG: fastavg_q <= bus_wdata[7];
            A_RSTCTL:  if (armed) rstctl_q <= bus_wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      rd_mux = 8'h00;
      unique case (bus_addr)
         A_REV:     rd_mux = ID_REV;
         A_PTYPE:   rd_mux = ID_PTYPE;
         A_PSUB:    rd_mux = ID_PSUB;
         A_STATUS:  rd_mux = {6'b0, pending, eoc};
         A_MODE:    rd_mux = mode_q;
         A_ENABLE:  rd_mux = {en_q, 7'b0};
         A_CHAN:    rd_mux = chan_q;
         A_DECIM:   rd_mux = decim_q;
         A_SETTLE:  rd_mux = settle_q;
         A_AVG:     rd_mux = avg_q;
         A_FASTAVG: rd_mux = {fastavg_q, 7'b0};
         A_RSTCTL:  rd_mux = armed ? rstctl_q : 8'h00;
         A_DEVIATE: rd_mux = DEV_BYTE;
         default:   rd_mux = 8'h00;
      endcase
      for (int i = 0; i < RES_BYTES; i++) begin
         if (bus_addr == 8'(A_RESULT + i)) rd_mux = result[i*8 +: 8];
      end
   end

   if (RDATA_REG) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      bus_rdata <= '0;
         else if (bus_rd) bus_rdata <= rd_mux;
      end
   end else begin : g_rd_comb
      assign bus_rdata = bus_rd ? rd_mux : '0;
   end

   assert_irq_clear_on_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> conv_start);
   assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !req_wr) |=> irq);
   assert_rstctl_guard_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> $stable(rstctl_q));
   assert_status_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(pending && eoc));
endmodule

// File: tb/test_csadc_regif.sv
module test_csadc_regif;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_rdata;
   logic        conv_start;
   logic [2:0]  conv_chan;
   logic        conv_done = 1'b0;
   logic [15:0] conv_sample = '0;
   logic        irq;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   csadc_regif i_csadc_regif (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
      .conv_sample(conv_sample), .irq(irq)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic done_pulse(input logic [15:0] s);
      @(negedge clk);
      conv_done = 1'b1; conv_sample = s;
      @(negedge clk);
      conv_done = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      check("R2 irq", 16'(irq), 16'h0);
      check("R2 conv_start", 16'(conv_start), 16'h0);
      rd(8'h08, d); check("R2 status", 16'(d), 16'h00);
      rd(8'h40, d); check("R2 mode", 16'(d), 16'h00);
      rd(8'h60, d); check("R2 result", 16'(d), 16'h00);
   endtask

   task automatic t_ident();
      logic [7:0] d;
      rd(8'h01, d); check("R1 rev", 16'(d), 16'h01);
      rd(8'h04, d); check("R1 type", 16'(d), 16'h08);
      rd(8'h05, d); check("R1 subtype", 16'(d), 16'h03);
      wr(8'h04, 8'hFF);
      rd(8'h04, d); check("R1 type after write", 16'(d), 16'h08);
      rd(8'hF4, d); check("R12 deviation", 16'(d), 16'h85);
      rd(8'h33, d); check("R12 unmapped", 16'(d), 16'h00);
   endtask

   task automatic t_config();
      logic [7:0] d;
      wr(8'h40, 8'h09); rd(8'h40, d); check("R3 mode", 16'(d), 16'h09);
      wr(8'h48, 8'hF5); rd(8'h48, d); check("R3 chan", 16'(d), 16'hF5);
      wr(8'h50, 8'h04); rd(8'h50, d); check("R3 decim", 16'(d), 16'h04);
      wr(8'h51, 8'h3C); rd(8'h51, d); check("R3 settle", 16'(d), 16'h3C);
      wr(8'h5A, 8'h02); rd(8'h5A, d); check("R3 avg", 16'(d), 16'h02);
      wr(8'h46, 8'hFF); rd(8'h46, d); check("R3 enable", 16'(d), 16'h80);
      wr(8'h5B, 8'h7F); rd(8'h5B, d); check("R3 fastavg", 16'(d), 16'h00);
   endtask

   task automatic t_disabled();
      logic [7:0] d;
      wr(8'h46, 8'h00);
      wr(8'h52, 8'h80);
      check("R5 no start disabled", 16'(conv_start), 16'h0);
      rd(8'h08, d); check("R5 status disabled", 16'(d), 16'h00);
      wr(8'h46, 8'h80);
      wr(8'h52, 8'h7F);
      check("R5 no start bit7 clear", 16'(conv_start), 16'h0);
      rd(8'h08, d); check("R5 status bit7 clear", 16'(d), 16'h00);
   endtask

   task automatic t_convert();
      logic [7:0] d;
      wr(8'h52, 8'h80);
      check("R4 start", 16'(conv_start), 16'h1);
      check("R4 chan", 16'(conv_chan), 16'h5);
      @(negedge clk);
      check("R4 single pulse", 16'(conv_start), 16'h0);
      rd(8'h08, d); check("R4 status pending", 16'(d), 16'h02);
      check("R7 irq low while pending", 16'(irq), 16'h0);
      done_pulse(16'hBEEF);
      rd(8'h08, d); check("R6 status done", 16'(d), 16'h01);
      rd(8'h60, d); check("R6 low byte", 16'(d), 16'hEF);
      rd(8'h61, d); check("R6 high byte", 16'(d), 16'hBE);
      check("R7 irq held", 16'(irq), 16'h1);
   endtask

   task automatic t_pending();
      logic [7:0] d;
      wr(8'h52, 8'h80);
      check("R7 irq cleared by request", 16'(irq), 16'h0);
      @(negedge clk);
      wr(8'h52, 8'h80);
      check("R8 no restart", 16'(conv_start), 16'h0);
      done_pulse(16'h1234);
      rd(8'h60, d); check("R6 second low", 16'(d), 16'h34);
      done_pulse(16'hFFFF);
      rd(8'h60, d); check("R9 stray done low", 16'(d), 16'h34);
      rd(8'h61, d); check("R9 stray done high", 16'(d), 16'h12);
      rd(8'h08, d); check("R9 status kept", 16'(d), 16'h01);
   endtask

   task automatic t_lock();
      logic [7:0] d;
      rd(8'hDA, d); check("R11 locked read", 16'(d), 16'h00);
      wr(8'hDA, 8'h04);
      wr(8'hD0, 8'hA5); rd(8'hDA, d); check("R11 locked write ignored", 16'(d), 16'h00);
      wr(8'hD0, 8'hA5); wr(8'hDA, 8'h04);
      wr(8'hD0, 8'hA5); rd(8'hDA, d); check("R10 unlocked readback", 16'(d), 16'h04);
      wr(8'hD0, 8'hA5); rd(8'h40, d); rd(8'hDA, d);
      check("R11 unlock consumed", 16'(d), 16'h00);
      wr(8'hD0, 8'h5A); rd(8'hDA, d); check("R11 wrong key", 16'(d), 16'h00);
      wr(8'hD0, 8'hA5); wr(8'hDA, 8'hFF);
      wr(8'hD0, 8'hA5); rd(8'hDA, d); check("R10 full byte", 16'(d), 16'hFF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ident();
      t_config();
      t_disabled();
      t_convert();
      t_pending();
      t_lock();
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule